// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external host read and write the processor's on-chip program and data memories over a 16-bit multiplexed address/data bus. The host controls the port with select, address-latch, read and write strobes. An acknowledge output tells the host when it may start the next phase. The host first sets a 14-bit word pointer and a memory-space bit. It can then stream a block of reads or writes, because the pointer advances by itself after every completed word.

The host strobes are qualified by select and pass through one synchronizing register into the processor clock. A request becomes a single memory cycle on the internal memory interface. Memory read data is returned combinationally by the memory in that cycle, and write data is committed at the end of that cycle. Program words are 24 bits wide and cross the 16-bit bus in two phases. Data-memory writes into the memory-mapped control region are suppressed. In host-boot mode, the core is held until program word 0 has been written through the port.

Top module: `host_mem_port`

## Requirements
- R1: A falling edge of (select AND address-latch) loads the pointer from the bus. Bus bits 13:0 give the word address and bit 14 gives the space (0 = program memory, 1 = data memory).
- R2: An address latch with bus bit 15 set is ignored. The pointer and the space keep their previous values.
- R3: A data-memory write writes {8'h00, bus[15:0]} to the pointed word in one memory cycle, then advances the pointer by one.
- R4: A data-memory read drives the pointed word's bits 15:0 on the output bus, then advances the pointer by one.
- R5: A program-memory write takes two phases. The first phase carries bits 23:8 and makes no memory access. The second phase carries bits 7:0 in the low byte, writes the full 24-bit word and only then advances the pointer.
- R6: A program-memory read takes two phases with a single memory access. The first phase returns bits 23:8. The second phase returns {8'h00, bits 7:0} and then advances the pointer.
- R7: Acknowledge is high after reset. It drops within one clock of a read or write strobe and rises again two clock edges after the strobe is first sampled, which is when the access has completed.
- R8: Each memory access asserts the memory request for exactly one clock cycle.
- R9: Data-memory writes at addresses at or above CTRL_BASE (default 0x3FE0) make no memory access, but the pointer still advances. Reads of that region are allowed.
- R10: While host-boot mode is selected, core hold stays high until a program-memory write to address 0 has completed.
- R11: The pointer wraps from 0x3FFF to 0x0000 and stays in the same memory space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| boot_host | input | 1 | Host-boot mode selected |
| hs_sel | input | 1 | Host port select, active high |
| hs_ale | input | 1 | Host address-latch strobe, active high |
| hs_rd | input | 1 | Host read strobe, active high |
| hs_wr | input | 1 | Host write strobe, active high |
| hs_ad_in | input | 16 | Multiplexed address/data from host |
| hs_ad_out | output | 16 | Read data to host |
| hs_ad_oe | output | 1 | Output enable for the host bus during a read |
| hs_ack | output | 1 | Port ready / previous access done |
| mem_req | output | 1 | Internal memory access cycle |
| mem_we | output | 1 | Write enable for the access |
| mem_dm | output | 1 | Space of the access: 0 = program, 1 = data |
| mem_addr | output | 14 | Word address |
| mem_wdata | output | 24 | Write data |
| mem_rdata | input | 24 | Read data, valid during the request cycle |
| core_hold | output | 1 | Holds the core during host boot |

## Verification
The assertions assume that the host follows the handshake. It holds the bus stable for at least two clocks after the address-latch strobe falls. It keeps each read or write strobe and its data in place until acknowledge returns. It issues no new strobe while an access is in flight, and it asserts read and write together never. The bench tasks drive every strobe on the falling clock edge, wait for acknowledge to return, and then leave two idle clocks before the next phase, so every stimulus stays within those assumptions.

// File: rtl/host_mem_port.sv
module host_mem_port #(
  parameter int AW = 14,
  parameter int BW = 16,
  parameter int PW = 24,
  parameter logic [AW-1:0] CTRL_BASE = 14'h3FE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_host,
  input  logic          hs_sel,
  input  logic          hs_ale,
  input  logic          hs_rd,
  input  logic          hs_wr,
  input  logic [BW-1:0] hs_ad_in,
  output logic [BW-1:0] hs_ad_out,
  output logic          hs_ad_oe,
  output logic          hs_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_dm,
  output logic [AW-1:0] mem_addr,
  output logic [PW-1:0] mem_wdata,
  input  logic [PW-1:0] mem_rdata,
  output logic          core_hold
);
  localparam int LW = PW - BW;

  logic ale_q, ale_p, rd_q, rd_p, wr_q, wr_p;
  logic ale_fall, start;
  logic acc, acc_wr, phase, booted;
  logic [AW-1:0] ptr;
  logic ptr_dm;
  logic [BW-1:0] wdat, hold, rdat;
  logic [LW-1:0] lowb;
  logic pm, prot;

  assign ale_fall = ale_p & ~ale_q;
  assign start    = ((rd_q & ~rd_p) | (wr_q & ~wr_p)) & ~acc;
  assign pm       = ~ptr_dm;
  assign prot     = ptr_dm & (ptr >= CTRL_BASE);

  assign hs_ack    = ~(start | acc);
  assign hs_ad_out = rdat;
  assign hs_ad_oe  = hs_sel & hs_rd;
  assign core_hold = boot_host & ~booted;

  assign mem_addr  = ptr;
  assign mem_dm    = ptr_dm;
  assign mem_we    = acc & acc_wr & (pm ? phase : ~prot);
  assign mem_req   = acc & (acc_wr ? (pm ? phase : ~prot) : (pm ? ~phase : 1'b1));
  assign mem_wdata = pm ? {hold, wdat[LW-1:0]} : {{LW{1'b0}}, wdat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ale_q, ale_p, rd_q, rd_p, wr_q, wr_p} <= '0;
      acc <= 1'b0; acc_wr <= 1'b0; phase <= 1'b0; booted <= 1'b0;
      ptr <= '0; ptr_dm <= 1'b0;
      wdat <= '0; hold <= '0; rdat <= '0; lowb <= '0;
    end else begin
      ale_q <= hs_sel & hs_ale; ale_p <= ale_q;
      rd_q  <= hs_sel & hs_rd;  rd_p  <= rd_q;
      wr_q  <= hs_sel & hs_wr;  wr_p  <= wr_q;
      acc <= start;
      if (start) begin
        acc_wr <= wr_q & ~wr_p;
        wdat   <= hs_ad_in;
      end
      if (ale_fall && !hs_ad_in[BW-1]) begin
        ptr    <= hs_ad_in[AW-1:0];
        ptr_dm <= hs_ad_in[AW];
        phase  <= 1'b0;
      end else if (acc) begin
        if (acc_wr) begin
          if (pm && !phase) hold <= wdat;
        end else if (pm) begin
          if (!phase) begin
            rdat <= mem_rdata[PW-1:LW];
            lowb <= mem_rdata[LW-1:0];
          end else
            rdat <= {{(BW-LW){1'b0}}, lowb};
        end else
          rdat <= mem_rdata[BW-1:0];
        if (pm && !phase)
          phase <= 1'b1;
        else begin
          phase <= 1'b0;
          ptr   <= ptr + 1'b1;
        end
        if (acc_wr && pm && phase && ptr == '0) booted <= 1'b1;
      end
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !(pm && !phase) && !ale_fall) |=> (mem_addr == $past(mem_addr) + 1'b1) && (mem_dm == $past(mem_dm))); // R11
  AST_PM_FIRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pm && !phase && !ale_fall) |=> $stable(mem_addr)); // R5
  AST_ONE_CYCLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R8
  AST_CTRL_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(mem_dm && mem_addr >= CTRL_BASE)); // R9
  AST_WE_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req); // R3
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> hs_ack); // R7
  AST_BOOT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_hold) && boot_host) |-> $past(mem_we && !mem_dm && mem_addr == '0)); // R10
endmodule

// File: tb/test_host_mem_port.sv
`timescale 1ns/1ps
module test_host_mem_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_host = 1'b1;
  logic hs_sel = 0, hs_ale = 0, hs_rd = 0, hs_wr = 0;
  logic [15:0] hs_ad_in = '0;
  logic [15:0] hs_ad_out;
  logic hs_ad_oe, hs_ack, mem_req, mem_we, mem_dm, core_hold;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;
  logic [23:0] pm_mem [0:63];
  logic [15:0] dm_mem [0:63];
  int req_cnt = 0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  host_mem_port i_host_mem_port (
    .clk(clk), .rst_n(rst_n), .boot_host(boot_host),
    .hs_sel(hs_sel), .hs_ale(hs_ale), .hs_rd(hs_rd), .hs_wr(hs_wr),
    .hs_ad_in(hs_ad_in), .hs_ad_out(hs_ad_out), .hs_ad_oe(hs_ad_oe), .hs_ack(hs_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_dm(mem_dm), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .core_hold(core_hold));

  assign mem_rdata = mem_dm ? {8'h00, dm_mem[mem_addr[5:0]]} : pm_mem[mem_addr[5:0]];

  always @(posedge clk) begin
    if (mem_req) req_cnt <= req_cnt + 1;
    if (mem_req && mem_we) begin
      if (mem_dm) dm_mem[mem_addr[5:0]] <= mem_wdata[15:0];
      else        pm_mem[mem_addr[5:0]] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic latch(input logic [15:0] a);
    @(negedge clk); hs_sel = 1; hs_ale = 1; hs_ad_in = a;
    @(negedge clk); hs_ale = 0;
    repeat (3) @(negedge clk);
    hs_sel = 0;
  endtask

  task automatic access(input bit wr, input logic [15:0] d, output logic [15:0] q);
    @(negedge clk); hs_sel = 1; hs_wr = wr; hs_rd = ~wr; hs_ad_in = d;
    @(negedge clk); chk(hs_ack == 1'b0, "R7 ack drop", hs_ack, 0);
    @(negedge clk);
    @(negedge clk); chk(hs_ack == 1'b1, "R7 ack return", hs_ack, 1);
    q = hs_ad_out;
    hs_sel = 0; hs_wr = 0; hs_rd = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic test_dm_rw;
    logic [15:0] q;
    int c0;
    latch(16'h4010);
    c0 = req_cnt;
    for (int i = 0; i < 3; i++) access(1, 16'hA100 + 16'(i), q);
    chk(req_cnt - c0 == 3, "R8 dm write accesses", req_cnt - c0, 3);
    latch(16'h4010);
    for (int i = 0; i < 3; i++) begin
      access(0, 16'h0, q);
      chk(q == 16'hA100 + 16'(i), "R3 R4 R1 dm readback", q, 16'hA100 + 16'(i));
    end
  endtask

  task automatic test_pm_rw;
    logic [15:0] q;
    int c0;
    latch(16'h0005);
    c0 = req_cnt;
    access(1, 16'h1234, q);
    chk(req_cnt == c0, "R5 no access on first phase", req_cnt - c0, 0);
    access(1, 16'h0056, q);
    access(1, 16'h789A, q);
    access(1, 16'h00BC, q);
    chk(req_cnt - c0 == 2, "R5 pm write accesses", req_cnt - c0, 2);
    chk(core_hold == 1'b1, "R10 hold kept", core_hold, 1);
    latch(16'h0005);
    c0 = req_cnt;
    access(0, 0, q); chk(q == 16'h1234, "R6 pm hi", q, 16'h1234);
    access(0, 0, q); chk(q == 16'h0056, "R6 pm lo", q, 16'h0056);
    access(0, 0, q); chk(q == 16'h789A, "R6 pm hi next", q, 16'h789A);
    access(0, 0, q); chk(q == 16'h00BC, "R6 pm lo next", q, 16'h00BC);
    chk(req_cnt - c0 == 2, "R6 pm read accesses", req_cnt - c0, 2);
  endtask

  task automatic test_bad_latch;
    logic [15:0] q;
    latch(16'h4020);
    access(1, 16'h5A5A, q);
    latch(16'hC030);
    access(1, 16'h6B6B, q);
    latch(16'h4020);
    access(0, 0, q); chk(q == 16'h5A5A, "R2 first word", q, 16'h5A5A);
    access(0, 0, q); chk(q == 16'h6B6B, "R2 pointer kept", q, 16'h6B6B);
  endtask

  task automatic test_protect;
    logic [15:0] q;
    int c0;
    latch(16'h7FDF);
    c0 = req_cnt;
    access(1, 16'h1111, q);
    access(1, 16'h2222, q);
    chk(req_cnt - c0 == 1, "R9 blocked access", req_cnt - c0, 1);
    latch(16'h7FDF);
    access(0, 0, q); chk(q == 16'h1111, "R9 below base", q, 16'h1111);
    access(0, 0, q); chk(q == 16'h5A5A, "R9 ctrl word unchanged", q, 16'h5A5A);
  endtask

  task automatic test_wrap_boot;
    logic [15:0] q;
    latch(16'h3FFF);
    access(1, 16'hCAFE, q); access(1, 16'h0011, q);
    chk(core_hold == 1'b1, "R10 hold before word 0", core_hold, 1);
    access(1, 16'hBEEF, q); access(1, 16'h0022, q);
    chk(core_hold == 1'b0, "R10 released", core_hold, 0);
    latch(16'h0000);
    access(0, 0, q); chk(q == 16'hBEEF, "R11 wrap hi", q, 16'hBEEF);
    access(0, 0, q); chk(q == 16'h0022, "R11 wrap lo", q, 16'h0022);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(hs_ack == 1'b1, "R7 reset ack", hs_ack, 1);
    chk(mem_req == 1'b0, "R8 reset req", mem_req, 0);
    chk(core_hold == 1'b1, "R10 reset hold", core_hold, 1);
    test_dm_rw();
    test_pm_rw();
    test_bad_latch();
    test_protect();
    test_wrap_boot();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule